// File: doc/BRIEF.md
# PC Card I/O Dynamic Bus Sizer

This block runs the external bus cycles for one PC Card-style address window on behalf of a CPU-side request port. Each accepted request is decoded by physical address. Requests outside the window are refused without any bus activity. Requests inside the window run either a memory-card cycle or an I/O-card cycle, selected by an address bit. Every cycle has three timed phases: address setup, strobe and hold. The strobe phase is stretched for as long as the card pulls its wait line low.

When the window is set up for a 16-bit bus and the core runs little-endian, a word I/O access samples the card's port-width input (`card_port8`) at the end of the setup phase. If that input is high, the card is treated as an 8-bit port. The block then runs a second byte cycle at the next address on its own, and merges the two read bytes into one 16-bit result. In big-endian mode the width input is disregarded and word data is byte-swapped across the bus.

The controller is a five-state machine:
- IDLE accepts a request. It goes to SETUP, or to FINISH when the request is refused.
- SETUP counts its cycles and then goes to STROBE.
- STROBE counts its cycles and leaves for HOLD only at an edge where wait is released.
- HOLD goes back to SETUP when a split access still owes its second byte. Otherwise it goes to FINISH.
- FINISH presents the response for one cycle and returns to IDLE.

Top module: `pcc_bus_sizer`

## Requirements
- R1: An access is in the window only when physical address bits [28:26] equal 3'b110. Any other access runs no bus cycle. It gives `rsp_done` with `rsp_err`=1 in the cycle after acceptance.
- R2: Inside the window, address bit 25 set selects an I/O cycle, which uses `card_iord_n` for reads and `card_iowr_n` for writes. Bit 25 clear selects a memory cycle, which uses `card_oe_n` for reads and `card_we_n` for writes. At most one strobe is low at any time.
- R3: Each bus cycle behaves as follows:
  - Card enables and address are driven for T_SETUP (2) cycles before the strobe.
  - The strobe stays low for at least T_STROBE (3) cycles with the address held stable.
  - Enables are held for T_HOLD (1) cycle after the strobe.
- R4: While `card_wait_n` is low, the strobe phase does not end. The strobe ends at the first edge after the minimum at which `card_wait_n` is high.
- R5: A little-endian word I/O read on a 16-bit window proceeds as follows when `card_port8` is high at the end of setup:
  - It runs two cycles. The first is at the even address with `card_ce_n`=2'b00. The second is at address+1 with `card_ce_n`=2'b10. The second setup follows the first hold directly.
  - The result is {second cycle low lane, first cycle low lane}.
  - `rsp_done` comes only after the second cycle.
- R6: A word access that is not split runs one cycle at the even address with `card_ce_n`=2'b00. In little-endian mode it passes data straight through.
- R7: In big-endian mode, `card_port8` has no effect and word accesses always run a single cycle. Word write data is driven as {wdata[7:0], wdata[15:8]}, and read data is returned byte-swapped.
- R8: Byte accesses and memory cycles are never split. On a 16-bit window, a byte at an even address uses `card_ce_n`=2'b10 with data on bits [7:0]. A byte at an odd address uses 2'b01 with data on bits [15:8]. A byte read returns its byte in `rsp_rdata[7:0]` with the upper byte zero.
- R9: With `cfg_bus16` low, byte cycles always use `card_ce_n`=2'b10 and bits [7:0]. Word accesses are refused with `rsp_err`=1 and no bus cycle.
- R10: `card_port8` is sampled once, at the edge that ends the first setup phase. A change during the strobe does not alter the access.
- R11: `req_ready` is high only in IDLE, and a request is taken when `req_valid` and `req_ready` are both high. `rsp_done` is a single-cycle pulse, followed by `req_ready` high.
- R12: In a split write, the first cycle drives the full word. The second cycle drives `wdata[15:8]` on bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_big_endian | input | 1 | Core byte order, 1 = big-endian |
| cfg_bus16 | input | 1 | Window configured for a 16-bit bus |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_addr | input | 29 | Physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access refused (valid with rsp_done) |
| rsp_rdata | output | 16 | Read result (valid with rsp_done) |
| card_addr | output | 26 | Card address |
| card_ce_n | output | 2 | Lane enables, bit 0 = low byte lane |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_wdata | output | 16 | Bus write data |
| card_rdata | input | 16 | Bus read data |
| card_wait_n | input | 1 | Card wait, low extends strobe |
| card_port8 | input | 1 | Card reports an 8-bit port when high |

## Verification
The width decision and the wait extension can fall in the same access. The sampling edge ends setup in the same cycle that a strobe would later be stretched, and a careless design would re-read the width input while waiting. The bench provokes this in two ways. It runs a split read with wait held low across several strobe cycles. It also runs a 16-bit-port read while the card model raises `card_port8` only during the strobe. The scoreboard judges each observed bus cycle against a queued expectation of address, lane enables, strobe kind, setup and strobe length and write lanes, and it judges the merged result when `rsp_done` arrives.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_FINISH
    } pcc_state_e;

    typedef enum logic [2:0] {
        LM_BYTE_LO,
        LM_BYTE_HI,
        LM_WORD,
        LM_WORD_SWAP,
        LM_SPLIT_LO,
        LM_SPLIT_HI
    } pcc_lane_e;

endpackage

// File: rtl/pcc_area_decode.sv
module pcc_area_decode #(
    parameter int ADDR_W   = 29,
    parameter int AREA_LSB = 26,
    parameter int AREA_ID  = 6,
    parameter int IO_BIT   = 25
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic                io,
    output logic [AREA_LSB-1:0] offs
);
    localparam int AREA_W = ADDR_W - AREA_LSB;

    // R1: window select on the upper address field
    assign hit  = (addr[ADDR_W-1:AREA_LSB] == AREA_W'(AREA_ID));
    // R2: I/O half of the window
    assign io   = addr[IO_BIT];
    assign offs = addr[AREA_LSB-1:0];
endmodule

// File: rtl/pcc_lane_steer.sv
module pcc_lane_steer
    import pcc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  pcc_lane_e             mode,
    input  logic [2*BYTE_W-1:0]   wdata,
    input  logic [2*BYTE_W-1:0]   bus_rdata,
    input  logic [2*BYTE_W-1:0]   rbuf,
    output logic [1:0]            ce_n,
    output logic [2*BYTE_W-1:0]   bus_wdata,
    output logic [2*BYTE_W-1:0]   rbuf_nx
);
    localparam int DATA_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] w_lo, w_hi, r_lo, r_hi, b_lo, b_hi;
    assign w_lo = wdata[BYTE_W-1:0];
    assign w_hi = wdata[DATA_W-1:BYTE_W];
    assign r_lo = bus_rdata[BYTE_W-1:0];
    assign r_hi = bus_rdata[DATA_W-1:BYTE_W];
    assign b_lo = rbuf[BYTE_W-1:0];
    assign b_hi = rbuf[DATA_W-1:BYTE_W];

    always_comb begin
        ce_n      = 2'b11;
        bus_wdata = '0;
        rbuf_nx   = rbuf;
        unique case (mode)
            LM_BYTE_LO: begin   // R8 R9
                ce_n      = 2'b10;
                bus_wdata = {w_lo, w_lo};
                rbuf_nx   = {{BYTE_W{1'b0}}, r_lo};
            end
            LM_BYTE_HI: begin   // R8
                ce_n      = 2'b01;
                bus_wdata = {w_lo, w_lo};
                rbuf_nx   = {{BYTE_W{1'b0}}, r_hi};
            end
            LM_WORD: begin      // R6
                ce_n      = 2'b00;
                bus_wdata = wdata;
                rbuf_nx   = bus_rdata;
            end
            LM_WORD_SWAP: begin // R7
                ce_n      = 2'b00;
                bus_wdata = {w_lo, w_hi};
                rbuf_nx   = {r_lo, r_hi};
            end
            LM_SPLIT_LO: begin  // R5 R12 first byte
                ce_n      = 2'b00;
                bus_wdata = wdata;
                rbuf_nx   = {b_hi, r_lo};
            end
            LM_SPLIT_HI: begin  // R5 R12 second byte
                ce_n      = 2'b10;
                bus_wdata = {w_hi, w_hi};
                rbuf_nx   = {r_lo, b_lo};
            end
            default: begin
                ce_n      = 2'b11;
            end
        endcase
    end
endmodule

// File: rtl/pcc_bus_sizer.sv
module pcc_bus_sizer
    import pcc_pkg::*;
#(
    parameter int ADDR_W   = 29,
    parameter int AREA_LSB = 26,
    parameter int AREA_ID  = 6,
    parameter int IO_BIT   = 25,
    parameter int BYTE_W   = 8,
    parameter int T_SETUP  = 2,
    parameter int T_STROBE = 3,
    parameter int T_HOLD   = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_big_endian,
    input  logic                  cfg_bus16,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_write,
    input  logic                  req_word,
    input  logic [2*BYTE_W-1:0]   req_wdata,
    output logic                  rsp_done,
    output logic                  rsp_err,
    output logic [2*BYTE_W-1:0]   rsp_rdata,
    output logic [AREA_LSB-1:0]   card_addr,
    output logic [1:0]            card_ce_n,
    output logic                  card_oe_n,
    output logic                  card_we_n,
    output logic                  card_iord_n,
    output logic                  card_iowr_n,
    output logic [2*BYTE_W-1:0]   card_wdata,
    input  logic [2*BYTE_W-1:0]   card_rdata,
    input  logic                  card_wait_n,
    input  logic                  card_port8
);
    localparam int DATA_W = 2 * BYTE_W;
    localparam int T_MAX  = (T_SETUP > T_STROBE) ?
                            ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD) :
                            ((T_STROBE > T_HOLD) ? T_STROBE : T_HOLD);
    localparam int CNT_W  = $clog2(T_MAX + 1);

    pcc_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    logic                 dec_hit, dec_io;
    logic [AREA_LSB-1:0]  dec_offs;

    logic                 write_q, word_q, io_q, be_q, bus16_q, err_q;
    logic                 port8_q, phase2_q;
    logic [AREA_LSB-1:0]  offs_q;
    logic [DATA_W-1:0]    wdata_q, rbuf;

    pcc_lane_e            lane_mode;
    logic [1:0]           lane_ce_n;
    logic [DATA_W-1:0]    lane_wdata, rbuf_nx;

    logic accept, refuse, samp_en, setup_end, strobe_end, hold_end, need_second;

    pcc_area_decode #(
        .ADDR_W   (ADDR_W),
        .AREA_LSB (AREA_LSB),
        .AREA_ID  (AREA_ID),
        .IO_BIT   (IO_BIT)
    ) u_decode (
        .addr (req_addr),
        .hit  (dec_hit),
        .io   (dec_io),
        .offs (dec_offs)
    );

    pcc_lane_steer #(
        .BYTE_W (BYTE_W)
    ) u_lanes (
        .mode      (lane_mode),
        .wdata     (wdata_q),
        .bus_rdata (card_rdata),
        .rbuf      (rbuf),
        .ce_n      (lane_ce_n),
        .bus_wdata (lane_wdata),
        .rbuf_nx   (rbuf_nx)
    );

    // R1 R9 R11: acceptance and refusal
    assign accept      = (state == ST_IDLE) && req_valid;
    assign refuse      = !dec_hit || (req_word && !cfg_bus16);
    // R5 R7 R8 R10: only little-endian word I/O first cycles look at width
    assign samp_en     = io_q && word_q && !be_q && !phase2_q;
    assign setup_end   = (state == ST_SETUP)  && (cnt == '0);
    assign strobe_end  = (state == ST_STROBE) && (cnt == '0) && card_wait_n;
    assign hold_end    = (state == ST_HOLD)   && (cnt == '0);
    assign need_second = port8_q && !phase2_q;

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx = refuse ? ST_FINISH : ST_SETUP;
                    cnt_nx   = CNT_W'(T_SETUP - 1);
                end
            end
            ST_SETUP: begin
                if (cnt == '0) begin
                    state_nx = ST_STROBE;
                    cnt_nx   = CNT_W'(T_STROBE - 1);
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            ST_STROBE: begin   // R4: wait only matters once the minimum is met
                if (cnt != '0) begin
                    cnt_nx = cnt - 1'b1;
                end else if (card_wait_n) begin
                    state_nx = ST_HOLD;
                    cnt_nx   = CNT_W'(T_HOLD - 1);
                end
            end
            ST_HOLD: begin
                if (cnt != '0) begin
                    cnt_nx = cnt - 1'b1;
                end else if (need_second) begin
                    state_nx = ST_SETUP;
                    cnt_nx   = CNT_W'(T_SETUP - 1);
                end else begin
                    state_nx = ST_FINISH;
                end
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q  <= 1'b0;
            word_q   <= 1'b0;
            io_q     <= 1'b0;
            be_q     <= 1'b0;
            bus16_q  <= 1'b0;
            err_q    <= 1'b0;
            port8_q  <= 1'b0;
            phase2_q <= 1'b0;
            offs_q   <= '0;
            wdata_q  <= '0;
            rbuf     <= '0;
        end else begin
            if (accept) begin
                write_q  <= req_write;
                word_q   <= req_word;
                io_q     <= dec_io;
                be_q     <= cfg_big_endian;
                bus16_q  <= cfg_bus16;
                err_q    <= refuse;
                port8_q  <= 1'b0;
                phase2_q <= 1'b0;
                offs_q   <= dec_offs;
                wdata_q  <= req_wdata;
                rbuf     <= '0;
            end
            // R10: single sampling edge, value held afterwards
            if (setup_end && samp_en) begin
                port8_q <= card_port8;
            end
            if (strobe_end && !write_q) begin
                rbuf <= rbuf_nx;
            end
            if (hold_end && need_second) begin
                phase2_q <= 1'b1;
            end
        end
    end

    // lane mode selection
    always_comb begin
        if (!word_q) begin
            lane_mode = (bus16_q && offs_q[0]) ? LM_BYTE_HI : LM_BYTE_LO;
        end else if (phase2_q) begin
            lane_mode = LM_SPLIT_HI;
        end else if (port8_q) begin
            lane_mode = LM_SPLIT_LO;
        end else if (be_q) begin
            lane_mode = LM_WORD_SWAP;
        end else begin
            lane_mode = LM_WORD;
        end
    end

    // outputs
    always_comb begin
        logic active, stb;
        active      = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        stb         = (state == ST_STROBE);
        req_ready   = (state == ST_IDLE);
        rsp_done    = (state == ST_FINISH);
        rsp_err     = err_q;
        rsp_rdata   = rbuf;
        card_ce_n   = active ? lane_ce_n : 2'b11;
        card_addr   = active ? {offs_q[AREA_LSB-1:1], phase2_q | (!word_q & offs_q[0])} : '0;
        card_oe_n   = !(stb && !io_q && !write_q);
        card_we_n   = !(stb && !io_q &&  write_q);
        card_iord_n = !(stb &&  io_q && !write_q);
        card_iowr_n = !(stb &&  io_q &&  write_q);
        card_wdata  = (active && write_q) ? lane_wdata : '0;
    end

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~card_oe_n, ~card_we_n, ~card_iord_n, ~card_iowr_n}) <= 1);

    // R3
    strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_oe_n && card_we_n && card_iord_n && card_iowr_n) |-> (card_ce_n != 2'b11));

    // R3
    strobe_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE) |=> ((state != ST_STROBE) || $stable(card_addr)));

    // R10
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE) |=> $stable(port8_q));

    // R7
    be_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && be_q) |=> (state != ST_SETUP));

    // R8
    byte_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && (!word_q || !io_q)) |=> (state != ST_SETUP));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));

    // R1
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && refuse) |=> (rsp_done && card_ce_n == 2'b11));
endmodule

// File: tb/pcc_bus_sizer_test.sv
`timescale 1ns/1ps
module pcc_bus_sizer_test;
    localparam int TS = 2, TSTB = 3, TH = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 1'b0, cfg_bus16 = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [28:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err;
    logic [15:0] rsp_rdata, card_wdata, card_rdata;
    logic [25:0] card_addr;
    logic [1:0]  card_ce_n;
    logic        card_oe_n, card_we_n, card_iord_n, card_iowr_n;
    logic        card_wait_n = 1'b1, card_port8;

    int nchk = 0, nfail = 0;
    int wait_len = 0;
    bit flip_en = 1'b0;

    typedef struct {
        int          kind;
        logic [25:0] addr;
        logic [1:0]  ce;
        logic [15:0] wd;
        int          pre;
        int          slen;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    pcc_bus_sizer #(.T_SETUP(TS), .T_STROBE(TSTB), .T_HOLD(TH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian), .cfg_bus16(cfg_bus16),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .card_addr(card_addr), .card_ce_n(card_ce_n), .card_oe_n(card_oe_n),
        .card_we_n(card_we_n), .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n),
        .card_wdata(card_wdata), .card_rdata(card_rdata), .card_wait_n(card_wait_n),
        .card_port8(card_port8)
    );

    // card model: address bit 8 marks an 8-bit port
    function automatic logic map8(input logic [25:0] a);
        return a[8];
    endfunction
    function automatic logic [7:0] bval(input logic [25:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction
    function automatic logic [15:0] card_rd(input logic [25:0] a);
        if (map8(a)) return {8'hEE, bval(a)};
        return {bval(a | 26'd1), bval(a & ~26'd1)};
    endfunction

    logic stb_any;
    assign stb_any    = !(card_oe_n && card_we_n && card_iord_n && card_iowr_n);
    assign card_port8 = map8(card_addr) ^ (flip_en && stb_any);
    assign card_rdata = card_rd(card_addr);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // monitor: observe bus cycles and pop expectations
    bit prev_stb = 1'b0;
    int pre_cnt = 0, stb_cnt = 0, obs_pre = 0, obs_kind = 0;
    logic [25:0] obs_addr;
    logic [1:0]  obs_ce;
    logic [15:0] obs_wd;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stb_any) begin
                if (!prev_stb) begin
                    obs_kind = !card_iowr_n ? 3 : !card_iord_n ? 2 : !card_we_n ? 1 : 0;
                    obs_addr = card_addr;
                    obs_ce   = card_ce_n;
                    obs_wd   = card_wdata;
                    obs_pre  = pre_cnt;
                    stb_cnt  = 1;
                end else begin
                    stb_cnt++;
                end
                card_wait_n <= (stb_cnt > wait_len);
            end else begin
                card_wait_n <= 1'b1;
                if (prev_stb) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R1", "unexpected bus cycle at", {6'd0, obs_addr}, 32'd0);
                    end else begin
                        exp_t e;
                        logic [15:0] m;
                        e = q.pop_front();
                        m = {{8{~e.ce[1]}}, {8{~e.ce[0]}}};
                        chk(obs_kind == e.kind, e.tag, "strobe kind", obs_kind, e.kind);
                        chk(obs_addr == e.addr, e.tag, "card address", {6'd0, obs_addr}, {6'd0, e.addr});
                        chk(obs_ce == e.ce, e.tag, "lane enables", {30'd0, obs_ce}, {30'd0, e.ce});
                        if (e.kind == 1 || e.kind == 3)
                            chk((obs_wd & m) == (e.wd & m), e.tag, "write lanes",
                                {16'd0, obs_wd & m}, {16'd0, e.wd & m});
                        chk(obs_pre == e.pre, e.tag, "setup length", obs_pre, e.pre);
                        chk(stb_cnt == e.slen, e.tag, "strobe length", stb_cnt, e.slen);
                    end
                    pre_cnt = 0;
                end
                if (card_ce_n != 2'b11) pre_cnt++;
                else pre_cnt = 0;
            end
            prev_stb = stb_any;
        end
    end

    task automatic push(input int kind, input logic [25:0] a, input logic [1:0] ce,
                        input logic [15:0] wd, input int pre, input string tag);
        exp_t e;
        e.kind = kind; e.addr = a; e.ce = ce; e.wd = wd; e.pre = pre;
        e.slen = (wait_len + 1 > TSTB) ? wait_len + 1 : TSTB;
        e.tag = tag;
        q.push_back(e);
    endtask

    // driver: compute expectations from the requirements, then issue the access
    task automatic access(input logic [28:0] a, input bit wr, input bit wd,
                          input logic [15:0] wdat, input int wl, input string tag);
        bit area, io, refuse;
        int kind;
        logic [25:0] x;
        logic [15:0] exp_rd;
        wait_len = wl;
        area   = (a[28:26] == 3'b110);
        io     = a[25];
        refuse = !area || (wd && !cfg_bus16);
        kind   = {io, wr};
        x      = a[25:0];
        exp_rd = 16'h0000;
        if (!refuse) begin
            if (!wd) begin
                if (cfg_bus16 && x[0]) begin
                    push(kind, x, 2'b01, {wdat[7:0], wdat[7:0]}, TS, tag);
                    exp_rd = {8'h00, card_rd(x)[15:8]};
                end else begin
                    push(kind, x, 2'b10, {wdat[7:0], wdat[7:0]}, TS, tag);
                    exp_rd = {8'h00, card_rd(x)[7:0]};
                end
            end else begin
                x[0] = 1'b0;
                if (io && !cfg_big_endian && map8(x)) begin
                    push(kind, x, 2'b00, wdat, TS, tag);
                    push(kind, x | 26'd1, 2'b10, {8'h00, wdat[15:8]}, TH + TS, tag);
                    exp_rd = {card_rd(x | 26'd1)[7:0], card_rd(x)[7:0]};
                end else if (cfg_big_endian) begin
                    push(kind, x, 2'b00, {wdat[7:0], wdat[15:8]}, TS, tag);
                    exp_rd = {card_rd(x)[7:0], card_rd(x)[15:8]};
                end else begin
                    push(kind, x, 2'b00, wdat, TS, tag);
                    exp_rd = card_rd(x);
                end
            end
        end
        @(negedge clk);
        chk(req_ready, "R11", "ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_word = wd; req_wdata = wdat;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11", "ready after accept", {31'd0, req_ready}, 32'd0);
        for (int i = 0; i < 200 && !rsp_done; i++) @(negedge clk);
        chk(rsp_done, tag, "done seen", {31'd0, rsp_done}, 32'd1);
        chk(rsp_err == refuse, tag, "error flag", {31'd0, rsp_err}, {31'd0, refuse});
        if (!wr && !refuse)
            chk(rsp_rdata == exp_rd, tag, "read data", {16'd0, rsp_rdata}, {16'd0, exp_rd});
        chk(q.size() == 0, tag, "bus cycles outstanding", q.size(), 32'd0);
        q.delete();
        @(negedge clk);
        chk(!rsp_done && req_ready, "R11", "done pulse width", {30'd0, rsp_done, req_ready}, 32'd1);
        wait_len = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready && !rsp_done, "R11", "reset handshake", {30'd0, req_ready, rsp_done}, 32'd2);
        chk(!stb_any && card_ce_n == 2'b11, "R3", "reset bus idle", {30'd0, card_ce_n}, 32'd3);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_big_endian = 1'b0; cfg_bus16 = 1'b1;
        access(29'h1A000040, 0, 1, 16'h0, 0, "R6");        // 16-bit port word read
        access(29'h1A000100, 0, 1, 16'h0, 0, "R5");        // 8-bit port split read
        access(29'h1A000100, 1, 1, 16'hC3A1, 0, "R12");    // split write
        access(29'h1A000141, 0, 0, 16'h0, 0, "R8");        // odd byte I/O read, never split
        access(29'h1A000040, 1, 0, 16'h0077, 0, "R8");     // even byte I/O write
        access(29'h18000100, 0, 1, 16'h0, 0, "R2");        // memory word read, never split
        access(29'h18000042, 1, 0, 16'h0055, 0, "R2");     // memory byte write
        access(29'h1C000000, 0, 1, 16'h0, 0, "R1");        // outside window
        access(29'h0A000000, 1, 0, 16'h1234, 0, "R1");
        access(29'h1A000040, 0, 1, 16'h0, 5, "R4");        // wait stretch
        access(29'h1A000100, 0, 1, 16'h0, 4, "R5");        // split with wait in both cycles
        flip_en = 1'b1;
        access(29'h1A000040, 0, 1, 16'h0, 4, "R10");       // width raised only during strobe
        flip_en = 1'b0;

        cfg_big_endian = 1'b1;
        access(29'h1A000100, 0, 1, 16'h0, 0, "R7");        // width input ignored
        access(29'h1A000040, 1, 1, 16'hBEEF, 0, "R7");     // swapped write
        access(29'h1A000041, 0, 0, 16'h0, 0, "R7");

        cfg_big_endian = 1'b0; cfg_bus16 = 1'b0;
        access(29'h1A000041, 0, 0, 16'h0, 0, "R9");        // low lane on 8-bit window
        access(29'h1A000043, 1, 0, 16'h00A6, 0, "R9");
        access(29'h1A000100, 0, 1, 16'h0, 0, "R9");        // word refused

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule